// File: doc/BRIEF.md
# Graphic RAM Command and Addressing Controller

This block sits behind a bus front end that has already assembled whole bytes. Each transaction is a byte marked as either a command or display data, and as either a read or a write. The block decodes the command bytes, keeps the page (X) and column (Y) address registers, and owns a display memory of 4 pages by 50 columns by 8 bits. A second read port on that memory is left free for a refresh engine.

Data writes store at the current address. Data reads go through a prefetch register, so the first read after an address change returns stale data. Both kinds of data access step the column in the direction chosen by command, wrapping modulo 50. The block also holds a display-enable flag, a count-direction flag and a start-page register. A busy window follows every accepted instruction. During that window, and during reset, only status reads are honoured.

Top module: `gram_cmd_ctrl`

## Requirements
- R1: While reset is low, a status read returns 0xF0. After reset is released the status is 0x60 (up mode, display off, not busy), disp_on is 0 and start_page is 0.
- R2: Command 0x39 enables the display and 0x38 disables it. Status bit 5 is 1 when the display is off. Memory contents are not changed by either command.
- R3: Command 0x3B selects counting up and 0x3A selects counting down. Status bit 6 is 1 in up mode.
- R4: A command whose bits 5..0 are 111110 copies bits 7..6 into start_page.
- R5: Any other command byte loads X from bits 7..6 and Y from bits 5..0. A Y field above 49 loads 0.
- R6: A data write stores the byte at (X, Y), which the refresh port then reads back one cycle after its address is applied. Y then steps by one in the selected direction.
- R7: Counting up, a data access at Y=49 leaves Y at 0.
- R8: Counting down, a data access at Y=0 leaves Y at 49.
- R9: A data read returns the prefetch register, then reloads it from (X, Y) before Y steps. The first read after an address set returns the old prefetch value, and the second read returns the data at the set address.
- R10: The status byte is {busy, up, display_off, reset, 4'b0000}, bit 7 first, and is returned on txn_rdata whenever txn_is_data is 0.
- R11: An accepted transaction other than a status read makes busy 1 for exactly BUSY_CYCLES (default 2) cycles after the accepting edge.
- R12: Transactions other than status reads that arrive while busy are dropped without any effect.
- R13: Transactions that arrive while reset is low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| txn_valid | input | 1 | A transaction is presented this cycle |
| txn_is_data | input | 1 | 1: display data, 0: command or status |
| txn_write | input | 1 | 1: write, 0: read |
| txn_wdata | input | 8 | Write byte |
| txn_rdata | output | 8 | Prefetch register when txn_is_data is 1, status byte otherwise |
| ref_page | input | 2 | Refresh read page |
| ref_col | input | 6 | Refresh read column |
| ref_data | output | 8 | Refresh read data, registered |
| disp_on | output | 1 | Display enable flag |
| start_page | output | 2 | Display start page |

## Verification
The situation hardest to bring about is a transaction landing inside the short busy window. The bench's normal transaction task always waits the window out, so it never produces one. Directed sequences therefore drive ports on consecutive cycles: a status read and a display-off command straight after an enable command, and a data write straight after an address set. A status read on the following cycle, and a refresh-port read of the two neighbouring columns, then show whether the dropped access touched anything.

// File: rtl/gram_pkg.sv
package gram_pkg;

   typedef enum logic [1:0] {
      CK_DISP  = 2'd0,
      CK_DIR   = 2'd1,
      CK_START = 2'd2,
      CK_ADDR  = 2'd3
   } cmd_kind_e;

   // status byte bit positions
   localparam int ST_BUSY  = 7;
   localparam int ST_UP    = 6;
   localparam int ST_OFF   = 5;
   localparam int ST_RESET = 4;

   function automatic cmd_kind_e decode_cmd(input logic [7:0] b);
      if (b[7:1] == 7'b0011100)    return CK_DISP;
      else if (b[7:1] == 7'b0011101) return CK_DIR;
      else if (b[5:0] == 6'b111110)  return CK_START;
      else                           return CK_ADDR;
   endfunction

endpackage

// File: rtl/gram_busy_timer.sv
module gram_busy_timer #(
   parameter int CYCLES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   generate
      if (CYCLES == 0) begin : g_none
         assign busy = 1'b0;
      end else begin : g_count
         localparam int CW = $clog2(CYCLES + 1);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       cnt <= '0;
            else if (start)   cnt <= CW'(CYCLES);
            else if (cnt != 0) cnt <= cnt - 1'b1;
         end

         assign busy = (cnt != 0);

         p_busy_after_start_r11 : assert property (@(posedge clk) disable iff (!rst_n)
            start |=> busy);
      end
   endgenerate
endmodule

// File: rtl/gram_col_counter.sv
module gram_col_counter #(
   parameter int COLS = 50,
   parameter int W    = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         step,
   input  logic         up,
   output logic [W-1:0] col
);
   localparam logic [W-1:0] LAST = W'(COLS - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col <= '0;
      end else if (load) begin
         col <= (load_val > LAST) ? '0 : load_val;
      end else if (step) begin
         if (up) col <= (col == LAST) ? '0 : col + 1'b1;
         else    col <= (col == '0) ? LAST : col - 1'b1;
      end
   end

   p_col_range_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      col <= LAST);
   p_wrap_up_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && up && col == LAST) |=> col == '0);
   p_wrap_down_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && !up && col == '0) |=> col == LAST);
endmodule

// File: rtl/gram_dpram.sv
module gram_dpram #(
   parameter int DEPTH   = 200,
   parameter int DW      = 8,
   parameter int AW      = 8,
   parameter int REF_REG = 1
) (
   input  logic          clk,
   input  logic          a_we,
   input  logic [AW-1:0] a_addr,
   input  logic [DW-1:0] a_wdata,
   output logic [DW-1:0] a_rdata,
   input  logic [AW-1:0] b_addr,
   output logic [DW-1:0] b_rdata
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (a_we) mem[a_addr] <= a_wdata;
   end

   assign a_rdata = mem[a_addr];

   generate
      if (REF_REG != 0) begin : g_reg
         always_ff @(posedge clk) b_rdata <= mem[b_addr];
      end else begin : g_comb
         assign b_rdata = mem[b_addr];
      end
   endgenerate
endmodule

// File: rtl/gram_cmd_ctrl.sv
module gram_cmd_ctrl
   import gram_pkg::*;
#(
   parameter int COLS        = 50,
   parameter int PAGES       = 4,
   parameter int DW          = 8,
   parameter int BUSY_CYCLES = 2,
   parameter int REF_REG     = 1,
   localparam int PAGE_W     = $clog2(PAGES),
   localparam int COL_W      = $clog2(COLS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              txn_valid,
   input  logic              txn_is_data,
   input  logic              txn_write,
   input  logic [DW-1:0]     txn_wdata,
   output logic [DW-1:0]     txn_rdata,
   input  logic [PAGE_W-1:0] ref_page,
   input  logic [COL_W-1:0]  ref_col,
   output logic [DW-1:0]     ref_data,
   output logic              disp_on,
   output logic [PAGE_W-1:0] start_page
);
   localparam int DEPTH  = PAGES * COLS;
   localparam int ADDR_W = $clog2(DEPTH);

   generate
      if (DW != 8) begin : g_bad_dw
         $error("command decoding needs an 8-bit byte");
      end
      if (PAGES != 4 || COLS < 2 || COLS > 62) begin : g_bad_geom
         $error("X field is 2 bits and Y field is 6 bits");
      end
   endgenerate

   logic [PAGE_W-1:0] x_q;
   logic              up_q;
   logic [DW-1:0]     pf_q;
   logic [COL_W-1:0]  col;
   logic              busy;
   logic [DW-1:0]     ram_a_rdata;
   logic [ADDR_W-1:0] a_addr, b_addr;

   logic status_rd, accept, cmd_acc, wr_acc, rd_acc;
   cmd_kind_e kind;

   assign status_rd = !txn_is_data && !txn_write;
   assign accept    = txn_valid && rst_n && (!busy || status_rd);
   assign cmd_acc   = accept && !txn_is_data && txn_write;
   assign wr_acc    = accept && txn_is_data && txn_write;
   assign rd_acc    = accept && txn_is_data && !txn_write;
   assign kind      = decode_cmd(txn_wdata);

   gram_busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
      .clk   (clk),
      .rst_n (rst_n),
      .start (cmd_acc || wr_acc || rd_acc),
      .busy  (busy)
   );

   gram_col_counter #(.COLS(COLS), .W(COL_W)) u_col (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cmd_acc && kind == CK_ADDR),
      .load_val (txn_wdata[COL_W-1:0]),
      .step     (wr_acc || rd_acc),
      .up       (up_q),
      .col      (col)
   );

   always_comb begin
      a_addr = ADDR_W'(x_q) * ADDR_W'(COLS) + ADDR_W'(col);
      b_addr = ADDR_W'(ref_page) * ADDR_W'(COLS) + ADDR_W'(ref_col);
   end

   gram_dpram #(.DEPTH(DEPTH), .DW(DW), .AW(ADDR_W), .REF_REG(REF_REG)) u_ram (
      .clk     (clk),
      .a_we    (wr_acc),
      .a_addr  (a_addr),
      .a_wdata (txn_wdata),
      .a_rdata (ram_a_rdata),
      .b_addr  (b_addr),
      .b_rdata (ref_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_q        <= '0;
         up_q       <= 1'b1;
         disp_on    <= 1'b0;
         start_page <= '0;
         pf_q       <= '0;
      end else begin
         if (cmd_acc) begin
            unique case (kind)
               CK_DISP:  disp_on    <= txn_wdata[0];
               CK_DIR:   up_q       <= txn_wdata[0];
               CK_START: start_page <= txn_wdata[7:6];
               CK_ADDR:  x_q        <= txn_wdata[7:6];
            endcase
         end
         if (rd_acc) pf_q <= ram_a_rdata;
      end
   end

   always_comb begin
      if (txn_is_data) begin
         txn_rdata = pf_q;
      end else begin
         txn_rdata           = '0;
         txn_rdata[ST_BUSY]  = busy || !rst_n;
         txn_rdata[ST_UP]    = up_q;
         txn_rdata[ST_OFF]   = !disp_on;
         txn_rdata[ST_RESET] = !rst_n;
      end
   end

   p_hold_while_busy_r12 : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && txn_valid && !status_rd) |=>
         ($stable(x_q) && $stable(col) && $stable(disp_on) && $stable(up_q)
          && $stable(start_page) && $stable(pf_q)));
   p_status_no_effect_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (txn_valid && status_rd && !busy) |=> ($stable(col) && !busy));
   p_read_steps_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (rd_acc && up_q && col == COL_W'(0)) |=> col == COL_W'(1));
endmodule

// File: tb/gram_cmd_ctrl_bench.sv
module gram_cmd_ctrl_bench;
   logic       clk = 0;
   logic       rst_n = 0;
   logic       txn_valid = 0, txn_is_data = 0, txn_write = 0;
   logic [7:0] txn_wdata = 0;
   logic [7:0] txn_rdata;
   logic [1:0] ref_page = 0;
   logic [5:0] ref_col = 0;
   logic [7:0] ref_data;
   logic       disp_on;
   logic [1:0] start_page;

   int checks = 0, errors = 0;
   logic [7:0] got;

   always #2 clk = ~clk;

   gram_cmd_ctrl u_gram_cmd_ctrl (
      .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_is_data(txn_is_data),
      .txn_write(txn_write), .txn_wdata(txn_wdata), .txn_rdata(txn_rdata),
      .ref_page(ref_page), .ref_col(ref_col), .ref_data(ref_data),
      .disp_on(disp_on), .start_page(start_page)
   );

   task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL R%0d actual %02h expected %02h", req, act, exp);
      end
   endtask

   // one transaction, then wait out the busy window
   task automatic txn(input logic d, input logic w, input logic [7:0] b, output logic [7:0] rd);
      @(negedge clk);
      txn_valid = 1; txn_is_data = d; txn_write = w; txn_wdata = b;
      #1 rd = txn_rdata;
      @(negedge clk);
      txn_valid = 0; txn_is_data = 0; txn_write = 0;
      @(negedge clk);
   endtask

   task automatic peek(input logic [7:0] pc, output logic [7:0] v);
      @(negedge clk);
      ref_page = pc[7:6]; ref_col = pc[5:0];
      @(posedge clk);
      #1 v = ref_data;
   endtask

   // {req, kind, byte, expect}; kind 0 cmd wr, 1 data wr, 2 status rd, 3 data rd, 4 refresh peek
   localparam int NV = 44;
   localparam logic [23:0] VEC [NV] = '{
      24'h2_0_39_00, 24'ha_2_00_40,                              // R2 R10 enable
      24'h6_0_05_00, 24'h6_1_A1_00, 24'h6_1_A2_00, 24'h6_1_A3_00, // R6 writes
      24'h5_0_45_00, 24'h6_1_B1_00,                              // R5 page 1
      24'h6_4_05_A1, 24'h6_4_06_A2, 24'h6_4_45_B1,
      24'h9_0_05_00, 24'h9_3_00_00, 24'h9_3_00_A1, 24'h9_3_00_A2, // R9 dummy first
      24'h9_0_45_00, 24'h9_3_00_A3, 24'h9_3_00_B1,               // R9 stale prefetch
      24'h3_0_3A_00, 24'h3_2_00_00,                              // R3 down
      24'h3_0_31_00, 24'h3_1_C0_00, 24'h3_1_C1_00, 24'h3_4_31_C0, 24'h3_4_30_C1,
      24'h8_0_00_00, 24'h8_1_D0_00, 24'h8_1_D1_00, 24'h8_4_00_D0, 24'h8_4_31_D1, // R8
      24'h3_0_3B_00, 24'h3_2_00_40,                              // R3 up
      24'h7_0_31_00, 24'h7_1_E0_00, 24'h7_1_E1_00, 24'h7_4_31_E0, 24'h7_4_00_E1, // R7
      24'h5_0_F3_00, 24'h5_1_F5_00, 24'h5_4_C0_F5,               // R5 Y above 49
      24'h2_0_38_00, 24'h2_2_00_60, 24'h2_4_00_E1, 24'h2_4_05_A1 // R2 RAM kept
   };

   initial begin
      #(200000 * 4);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // R1 reset state
      repeat (2) @(negedge clk);
      txn_valid = 1; txn_is_data = 0; txn_write = 0;
      #1 check(1, txn_rdata, 8'hF0);
      check(1, {7'd0, disp_on}, 8'h00);
      check(1, {6'd0, start_page}, 8'h00);
      @(negedge clk);
      txn_valid = 0;
      rst_n = 1;
      txn(0, 0, 8'h00, got); check(1, got, 8'h60);

      for (int i = 0; i < NV; i++) begin
         logic [3:0] rq, kd;
         logic [7:0] by, ex;
         {rq, kd, by, ex} = VEC[i];
         case (kd)
            4'd0: txn(0, 1, by, got);
            4'd1: txn(1, 1, by, got);
            4'd2: begin txn(0, 0, 8'h00, got); check(int'(rq), got, ex); end
            4'd3: begin txn(1, 0, 8'h00, got); check(int'(rq), got, ex); end
            default: begin peek(by, got); check(int'(rq), got, ex); end
         endcase
      end

      // R4 start page
      txn(0, 1, 8'hBE, got); check(4, {6'd0, start_page}, 8'h02);
      txn(0, 1, 8'h7E, got); check(4, {6'd0, start_page}, 8'h01);
      check(2, {7'd0, disp_on}, 8'h00);

      // R11 busy window, R12 drop during busy
      @(negedge clk);
      txn_valid = 1; txn_is_data = 0; txn_write = 1; txn_wdata = 8'h39;
      @(negedge clk);
      txn_write = 0;
      #1 check(11, txn_rdata, 8'hC0);
      @(negedge clk);
      txn_write = 1; txn_wdata = 8'h38;      // dropped, R12
      @(negedge clk);
      txn_write = 0;
      #1 check(11, txn_rdata, 8'h40);        // busy over after 2 cycles, still on
      @(negedge clk);
      txn_valid = 0;
      check(12, {7'd0, disp_on}, 8'h01);

      @(negedge clk);
      txn_valid = 1; txn_is_data = 0; txn_write = 1; txn_wdata = 8'h05;
      @(negedge clk);
      txn_is_data = 1; txn_wdata = 8'h77;    // dropped, R12
      @(negedge clk);
      txn_valid = 0;
      @(negedge clk);
      txn_valid = 1; txn_wdata = 8'h55;
      @(negedge clk);
      txn_valid = 0; txn_is_data = 0; txn_write = 0;
      @(negedge clk);
      peek(8'h05, got); check(12, got, 8'h55);
      peek(8'h06, got); check(12, got, 8'hA2);

      // R13 reset blocks transactions
      @(negedge clk);
      rst_n = 0;
      txn_valid = 1; txn_is_data = 0; txn_write = 0;
      #1 check(13, txn_rdata, 8'hF0);
      @(negedge clk);
      txn_write = 1; txn_wdata = 8'h39;
      @(negedge clk);
      txn_valid = 0; txn_write = 0;
      rst_n = 1;
      txn(0, 0, 8'h00, got); check(13, got, 8'h60);
      check(13, {7'd0, disp_on}, 8'h00);
      check(1, {6'd0, start_page}, 8'h00);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule